// File: doc/BRIEF.md
# Outbound Write Flush Buffer

This block is a small first-in first-out store for write traffic leaving a processor. It holds uncached stores and dirty cache-line write-backs until a bus master takes them. Every slot holds a 100-bit payload: 64 bits of data, a 32-bit physical address and a 4-bit size code. Single-word and double-word uncached writes use one slot each. A data-cache line write-back brings two doublewords under one address and uses two slots. An instruction-cache line write brings four doublewords and uses every slot.

A request is taken whole or not at all. When the free slots cannot hold all of a request, the stall output is raised for as long as the request is offered and the space is short. The drain side shows the oldest slot and removes it when the bus master accepts it. Slots that belong to one block are marked as the first and last beat of a single transaction, and they all carry the block address. A write-back of a dirty victim can be held until the read for the missing line has gone out. The drain side does not show held slots until the fetch-issued pulse arrives. The producer keeps running while data drains.

Top module: `egress_wbuf`

## Requirements
- R1: During reset and in the first cycles after it, out_valid is 0 and req_stall is 0 while req_valid is 0. The buffer starts empty, so four single-slot requests are accepted after reset.
- R2: A single-word request (req_kind 0) or a double-word request (req_kind 1) uses exactly one slot. Any mix of four such requests is accepted. A fifth request, offered while none have drained, is stalled.
- R3: A data-cache block (req_kind 2) uses two slots, so two blocks are held at once. A further block is stalled until two slots are free.
- R4: An instruction-cache block (req_kind 3) is accepted only when all four slots are free. While it is stalled, no part of it enters the buffer. After it is accepted, any further request is stalled.
- R5: req_stall is high exactly when req_valid is high and the free slots are fewer than the request needs. It falls in the cycle that follows the clock edge at which enough slots drained.
- R6: The drain side presents slots in strict arrival order. While out_valid is high and out_ready is low, the presented address, data and size stay unchanged. A slot is removed at a clock edge where both out_valid and out_ready are high.
- R7: Every slot of a block carries the block address. The drain side presents the block data beats in order, beat 0 first, where beat i is req_data[64*i+63:64*i]. out_first is 1 only on the first slot of a request and out_last is 1 only on its final slot. A single-slot request shows both flags as 1.
- R8: The size code is 4'b0001 for a single word, 4'b0010 for a double word, 4'b0100 for a data-cache block and 4'b1000 for an instruction-cache block.
- R9: Slots written with req_victim set are held, and out_valid stays 0 while a held slot is the oldest. Later slots wait behind it. A one-cycle fetch_issued pulse releases every held slot, and out_valid rises in the cycle after that pulse.
- R10: A push and a pop may happen at the same clock edge, and occupancy then changes by the pushed slot count minus one. Admission uses the occupancy at the start of the cycle, so a slot drained in the same cycle does not make room for that cycle's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A write request is offered |
| req_kind | input | 2 | 0 single word, 1 double word, 2 data-cache block, 3 instruction-cache block |
| req_victim | input | 1 | The request is a dirty-victim write-back that must wait for fetch_issued |
| req_addr | input | 32 | Physical address of the request |
| req_data | input | 256 | Data beats; beat i sits at bits 64*i+63:64*i |
| req_stall | output | 1 | The request cannot be admitted this cycle |
| fetch_issued | input | 1 | Pulse: the read for the missing line has been issued, so held slots are released |
| out_valid | output | 1 | The oldest slot is ready to drain |
| out_ready | input | 1 | The bus master takes the presented slot |
| out_addr | output | 32 | Address of the presented slot |
| out_data | output | 64 | Data of the presented slot |
| out_size | output | 4 | Size code of the presented slot |
| out_first | output | 1 | The presented slot starts a transaction |
| out_last | output | 1 | The presented slot ends a transaction |

## Verification
req_stall is combinational from the occupancy register and the request inputs. The bench reads it one time unit after it drives a request on the falling edge, in the same cycle. A pushed slot, a released hold or a freed slot shows on the outputs after one rising edge, so the bench checks out_valid, the head fields and the dropped stall at the following falling edge. Every drain step samples the head at a falling edge and then raises out_ready across one rising edge. The bench checks admission results indirectly: it counts how many later requests fit, and then it drains the buffer in order.

// File: rtl/ewb_pkg.sv
package ewb_pkg;

  typedef enum logic [1:0] {
    RK_WORD  = 2'd0,
    RK_DWORD = 2'd1,
    RK_DBLK  = 2'd2,
    RK_IBLK  = 2'd3
  } req_kind_e;

  localparam logic [3:0] SZ_WORD  = 4'b0001;
  localparam logic [3:0] SZ_DWORD = 4'b0010;
  localparam logic [3:0] SZ_DBLK  = 4'b0100;
  localparam logic [3:0] SZ_IBLK  = 4'b1000;

  // one 100-bit slot payload
  typedef struct packed {
    logic [63:0] data;
    logic [31:0] addr;
    logic [3:0]  size;
  } ewb_payload_t;

  function automatic logic [3:0] size_code(input req_kind_e k);
    logic [3:0] s;
    unique case (k)
      RK_WORD:  s = SZ_WORD;
      RK_DWORD: s = SZ_DWORD;
      RK_DBLK:  s = SZ_DBLK;
      default:  s = SZ_IBLK;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ewb_admit.sv
// Admission control: slot demand per request, stall, occupancy count.
module ewb_admit
  import ewb_pkg::*;
#(
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned DBLK_BEATS = 2,
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  req_kind_e     req_kind,
  input  logic          pop,
  output logic          accept,
  output logic          stall,
  output logic [CW-1:0] need,
  output logic [CW-1:0] occ
);

  logic [CW-1:0] free_slots;
  logic [CW-1:0] occ_nxt;
  logic          occ_en;

  always_comb begin
    unique case (req_kind)
      RK_WORD,
      RK_DWORD: need = CW'(1);
      RK_DBLK:  need = CW'(DBLK_BEATS);
      default:  need = CW'(DEPTH);
    endcase
  end

  // admission sees occupancy at cycle start; a same-cycle pop is not credited
  assign free_slots = CW'(DEPTH) - occ;
  assign accept     = req_valid && (need <= free_slots);
  assign stall      = req_valid && (need > free_slots);

  always_comb begin
    occ_nxt = occ;
    if (accept) occ_nxt = occ_nxt + need;
    if (pop)    occ_nxt = occ_nxt - CW'(1);
  end

  assign occ_en = accept || pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ <= '0;
    else if (occ_en) occ <= occ_nxt;
  end

endmodule

// File: rtl/ewb_store.sv
// Slot storage: a circular array that writes a whole request in one cycle.
module ewb_store
  import ewb_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [CW-1:0]      need,
  input  logic [31:0]        in_addr,
  input  logic [DEPTH*64-1:0] in_beats,
  input  logic [3:0]         in_size,
  input  logic               in_victim,
  input  logic               fetch_issued,
  input  logic               pop,
  output ewb_payload_t       head_pl,
  output logic               head_cont,
  output logic               head_last,
  output logic               head_held
);

  logic [PW-1:0] wr_ptr, wr_ptr_nxt;
  logic [PW-1:0] rd_ptr, rd_ptr_nxt;

  ewb_payload_t      pl_all [DEPTH];
  logic [DEPTH-1:0]  cont_all;
  logic [DEPTH-1:0]  last_all;
  logic [DEPTH-1:0]  held_all;

  // pointer arithmetic wraps modulo DEPTH (DEPTH is a power of two)
  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    if (push) wr_ptr_nxt = wr_ptr + PW'(need);
    if (pop)  rd_ptr_nxt = rd_ptr + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr_nxt;
      if (pop)  rd_ptr <= rd_ptr_nxt;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [PW-1:0] ofs;
    logic          we;
    ewb_payload_t  pl_r, pl_nxt;
    logic          cont_r, last_r, cont_nxt, last_nxt;
    logic          held_r, held_nxt, held_en;

    // beat index this slot would take in the request being pushed
    assign ofs = PW'(e) - wr_ptr;
    assign we  = push && (CW'(ofs) < need);

    always_comb begin
      pl_nxt.data = in_beats[ofs*64 +: 64];
      pl_nxt.addr = in_addr;
      pl_nxt.size = in_size;
      cont_nxt    = (ofs != '0);
      last_nxt    = (CW'(ofs) == (need - CW'(1)));
    end

    always_ff @(posedge clk) begin
      if (we) begin
        pl_r   <= pl_nxt;
        cont_r <= cont_nxt;
        last_r <= last_nxt;
      end
    end

    always_comb begin
      if (we)                held_nxt = in_victim;
      else if (fetch_issued) held_nxt = 1'b0;
      else                   held_nxt = held_r;
    end
    assign held_en = we || fetch_issued;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held_r <= 1'b0;
      else if (held_en) held_r <= held_nxt;
    end

    assign pl_all[e]   = pl_r;
    assign cont_all[e] = cont_r;
    assign last_all[e] = last_r;
    assign held_all[e] = held_r;
  end

  assign head_pl   = pl_all[rd_ptr];
  assign head_cont = cont_all[rd_ptr];
  assign head_last = last_all[rd_ptr];
  assign head_held = held_all[rd_ptr];

endmodule

// File: rtl/ewb_drain.sv
// Drain side: shows the oldest slot unless it is held, pops on acceptance.
module ewb_drain
  import ewb_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occ,
  input  ewb_payload_t  head_pl,
  input  logic          head_cont,
  input  logic          head_last,
  input  logic          head_held,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          pop,
  output logic [31:0]   out_addr,
  output logic [63:0]   out_data,
  output logic [3:0]    out_size,
  output logic          out_first,
  output logic          out_last
);

  logic any_slot;

  assign any_slot  = (occ != '0);
  assign out_valid = any_slot && !head_held;
  assign pop       = out_valid && out_ready;

  // fields are gated so an idle port carries constant zeros
  always_comb begin
    if (out_valid) begin
      out_addr  = head_pl.addr;
      out_data  = head_pl.data;
      out_size  = head_pl.size;
      out_first = !head_cont;
      out_last  = head_last;
    end else begin
      out_addr  = '0;
      out_data  = '0;
      out_size  = '0;
      out_first = 1'b0;
      out_last  = 1'b0;
    end
  end

  // clk and rst_n kept on the port list so a registered output stage can be
  // placed here without touching the parent
  logic unused_ok;
  assign unused_ok = clk ^ rst_n;

endmodule

// File: rtl/egress_wbuf.sv
module egress_wbuf
  import ewb_pkg::*;
#(
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned DBLK_BEATS = 2,
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic                req_victim,
  input  logic [31:0]         req_addr,
  input  logic [DEPTH*64-1:0] req_data,
  output logic                req_stall,
  input  logic                fetch_issued,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [31:0]         out_addr,
  output logic [63:0]         out_data,
  output logic [3:0]          out_size,
  output logic                out_first,
  output logic                out_last
);

  // asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  req_kind_e     kind;
  logic          accept, pop, stall_raw;
  logic [CW-1:0] need, occ;
  ewb_payload_t  head_pl;
  logic          head_cont, head_last, head_held;

  assign kind      = req_kind_e'(req_kind);
  assign req_stall = stall_raw;

  ewb_admit #(
    .DEPTH      (DEPTH),
    .DBLK_BEATS (DBLK_BEATS)
  ) u_admit (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_kind  (kind),
    .pop       (pop),
    .accept    (accept),
    .stall     (stall_raw),
    .need      (need),
    .occ       (occ)
  );

  ewb_store #(
    .DEPTH (DEPTH)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .push         (accept),
    .need         (need),
    .in_addr      (req_addr),
    .in_beats     (req_data),
    .in_size      (size_code(kind)),
    .in_victim    (req_victim),
    .fetch_issued (fetch_issued),
    .pop          (pop),
    .head_pl      (head_pl),
    .head_cont    (head_cont),
    .head_last    (head_last),
    .head_held    (head_held)
  );

  ewb_drain #(
    .DEPTH (DEPTH)
  ) u_drain (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .occ       (occ),
    .head_pl   (head_pl),
    .head_cont (head_cont),
    .head_last (head_last),
    .head_held (head_held),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .pop       (pop),
    .out_addr  (out_addr),
    .out_data  (out_data),
    .out_size  (out_size),
    .out_first (out_first),
    .out_last  (out_last)
  );

endmodule

// File: rtl/ewb_checker.sv
module ewb_checker #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_kind,
  input logic          req_stall,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_addr,
  input logic [63:0]   out_data,
  input logic [3:0]    out_size,
  input logic          out_first,
  input logic          out_last,
  input logic [CW-1:0] occ
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH)); // R2

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_stall) |=> (occ != '0)); // R2

  AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_stall |-> req_valid); // R5

  AST_IBLK_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_stall && (req_kind == 2'd3)) |-> (occ == '0)); // R4

  AST_HEAD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_addr) && $stable(out_data) && $stable(out_size))); // R6

  AST_SINGLE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_size[2] && !out_size[3]) |-> (out_first && out_last)); // R7

  AST_SIZE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_size) == 1)); // R8

endmodule

bind egress_wbuf ewb_checker #(.DEPTH(DEPTH)) u_ewb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_stall (req_stall),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_data  (out_data),
  .out_size  (out_size),
  .out_first (out_first),
  .out_last  (out_last),
  .occ       (occ)
);

// File: tb/egress_wbuf_bench.sv
`timescale 1ns/1ps
module egress_wbuf_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_victim, fetch_issued, out_ready;
  logic [1:0]   req_kind;
  logic [31:0]  req_addr;
  logic [255:0] req_data;
  logic         req_stall, out_valid, out_first, out_last;
  logic [31:0]  out_addr;
  logic [63:0]  out_data;
  logic [3:0]   out_size;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  egress_wbuf u_egress_wbuf (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_victim   (req_victim),
    .req_addr     (req_addr),
    .req_data     (req_data),
    .req_stall    (req_stall),
    .fetch_issued (fetch_issued),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_addr     (out_addr),
    .out_data     (out_data),
    .out_size     (out_size),
    .out_first    (out_first),
    .out_last     (out_last)
  );

  function automatic logic [255:0] beats(input logic [63:0] b);
    return {b + 64'd3, b + 64'd2, b + 64'd1, b};
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // offer one request for one cycle; stall is read in that cycle
  task automatic offer(input logic [1:0] k, input logic [31:0] a,
                       input logic [255:0] d, input logic v,
                       input logic exp_stall, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_data = d; req_victim = v;
    #1 chk(rq, "req_stall", {63'd0, req_stall}, {63'd0, exp_stall});
    @(posedge clk);
    #1 req_valid = 1'b0; req_victim = 1'b0;
  endtask

  // check the presented head, then take it
  task automatic take(input logic [31:0] a, input logic [63:0] d,
                      input logic [3:0] sz, input logic f, input logic l,
                      input string rq);
    @(negedge clk);
    chk(rq, "out_valid", {63'd0, out_valid}, 64'd1);
    chk(rq, "out_addr",  {32'd0, out_addr},  {32'd0, a});
    chk(rq, "out_data",  out_data, d);
    chk(rq, "out_size",  {60'd0, out_size},  {60'd0, sz});
    chk(rq, "out_first", {63'd0, out_first}, {63'd0, f});
    chk(rq, "out_last",  {63'd0, out_last},  {63'd0, l});
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic expect_idle(input string rq);
    @(negedge clk);
    chk(rq, "out_valid idle", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0;
    req_data = '0; req_victim = 1'b0; fetch_issued = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "out_valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R1", "req_stall in reset", {63'd0, req_stall}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk("R1", "req_stall after reset", {63'd0, req_stall}, 64'd0);
  endtask

  task automatic t_singles;
    offer(2'd0, 32'h1000, beats(64'hA0), 1'b0, 1'b0, "R1");
    offer(2'd1, 32'h1008, beats(64'hB0), 1'b0, 1'b0, "R2");
    offer(2'd0, 32'h1010, beats(64'hC0), 1'b0, 1'b0, "R2");
    offer(2'd1, 32'h1018, beats(64'hD0), 1'b0, 1'b0, "R2");
    // fifth waits for room: stall holds, then drops one cycle after a pop
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_addr = 32'h1020; req_data = beats(64'hE0);
    #1 chk("R2", "fifth stalls", {63'd0, req_stall}, 64'd1);
    @(negedge clk);
    chk("R5", "stall held while full", {63'd0, req_stall}, 64'd1);
    chk("R6", "head is first pushed", {32'd0, out_addr}, 64'h1000);
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
    @(negedge clk);
    #1 chk("R5", "stall drops after pop", {63'd0, req_stall}, 64'd0);
    @(posedge clk);
    #1 req_valid = 1'b0;
    take(32'h1008, 64'hB0, 4'b0010, 1'b1, 1'b1, "R8");
    take(32'h1010, 64'hC0, 4'b0001, 1'b1, 1'b1, "R6");
    take(32'h1018, 64'hD0, 4'b0010, 1'b1, 1'b1, "R7");
    take(32'h1020, 64'hE0, 4'b0001, 1'b1, 1'b1, "R6");
    expect_idle("R6");
  endtask

  task automatic t_dblocks;
    offer(2'd2, 32'h2000, beats(64'h200), 1'b0, 1'b0, "R3");
    offer(2'd2, 32'h2040, beats(64'h300), 1'b0, 1'b0, "R3");
    offer(2'd2, 32'h2080, beats(64'h400), 1'b0, 1'b1, "R3");
    offer(2'd0, 32'h20C0, beats(64'h500), 1'b0, 1'b1, "R3");
    take(32'h2000, 64'h200, 4'b0100, 1'b1, 1'b0, "R7");
    offer(2'd2, 32'h2080, beats(64'h400), 1'b0, 1'b1, "R3");
    take(32'h2000, 64'h201, 4'b0100, 1'b0, 1'b1, "R7");
    offer(2'd2, 32'h2080, beats(64'h400), 1'b0, 1'b0, "R3");
    take(32'h2040, 64'h300, 4'b0100, 1'b1, 1'b0, "R7");
    take(32'h2040, 64'h301, 4'b0100, 1'b0, 1'b1, "R7");
    take(32'h2080, 64'h400, 4'b0100, 1'b1, 1'b0, "R6");
    take(32'h2080, 64'h401, 4'b0100, 1'b0, 1'b1, "R6");
    expect_idle("R3");
  endtask

  task automatic t_iblock;
    offer(2'd0, 32'h3000, beats(64'h600), 1'b0, 1'b0, "R4");
    offer(2'd3, 32'h3100, beats(64'h700), 1'b0, 1'b1, "R4");
    take(32'h3000, 64'h600, 4'b0001, 1'b1, 1'b1, "R4");
    expect_idle("R4");   // nothing of the stalled block got in
    offer(2'd3, 32'h3100, beats(64'h700), 1'b0, 1'b0, "R4");
    offer(2'd0, 32'h3200, beats(64'h800), 1'b0, 1'b1, "R4");
    take(32'h3100, 64'h700, 4'b1000, 1'b1, 1'b0, "R7");
    take(32'h3100, 64'h701, 4'b1000, 1'b0, 1'b0, "R7");
    take(32'h3100, 64'h702, 4'b1000, 1'b0, 1'b0, "R7");
    take(32'h3100, 64'h703, 4'b1000, 1'b0, 1'b1, "R7");
    expect_idle("R4");
  endtask

  task automatic t_victim;
    offer(2'd2, 32'h4000, beats(64'h900), 1'b1, 1'b0, "R9");
    offer(2'd1, 32'h4100, beats(64'hA00), 1'b0, 1'b0, "R9");
    expect_idle("R9");
    expect_idle("R9");
    @(negedge clk);
    fetch_issued = 1'b1;
    @(posedge clk);
    #1 fetch_issued = 1'b0;
    take(32'h4000, 64'h900, 4'b0100, 1'b1, 1'b0, "R9");
    take(32'h4000, 64'h901, 4'b0100, 1'b0, 1'b1, "R9");
    take(32'h4100, 64'hA00, 4'b0010, 1'b1, 1'b1, "R9");
    expect_idle("R9");
  endtask

  task automatic t_same_cycle;
    offer(2'd0, 32'h5000, beats(64'hB00), 1'b0, 1'b0, "R10");
    offer(2'd0, 32'h5004, beats(64'hB10), 1'b0, 1'b0, "R10");
    offer(2'd0, 32'h5008, beats(64'hB20), 1'b0, 1'b0, "R10");
    offer(2'd0, 32'h500C, beats(64'hB30), 1'b0, 1'b0, "R10");
    // full: a pop in this cycle does not make room for this cycle's request
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_addr = 32'h5010; req_data = beats(64'hB40);
    out_ready = 1'b1;
    #1 chk("R10", "no credit for same-cycle pop", {63'd0, req_stall}, 64'd1);
    chk("R10", "popped head", {32'd0, out_addr}, 64'h5000);
    @(posedge clk);
    #1 req_valid = 1'b0; out_ready = 1'b0;
    // three held: push and pop together keep occupancy at three
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd1; req_addr = 32'h5018; req_data = beats(64'hB50);
    out_ready = 1'b1;
    #1 chk("R10", "push with pop accepted", {63'd0, req_stall}, 64'd0);
    chk("R10", "popped head", {32'd0, out_addr}, 64'h5004);
    @(posedge clk);
    #1 req_valid = 1'b0; out_ready = 1'b0;
    offer(2'd0, 32'h5020, beats(64'hB60), 1'b0, 1'b0, "R10");
    offer(2'd0, 32'h5028, beats(64'hB70), 1'b0, 1'b1, "R10");
    take(32'h5008, 64'hB20, 4'b0001, 1'b1, 1'b1, "R10");
    take(32'h500C, 64'hB30, 4'b0001, 1'b1, 1'b1, "R10");
    take(32'h5018, 64'hB50, 4'b0010, 1'b1, 1'b1, "R10");
    take(32'h5020, 64'hB60, 4'b0001, 1'b1, 1'b1, "R10");
    expect_idle("R10");
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    t_reset();
    t_singles();
    t_dblocks();
    t_iblock();
    t_victim();
    t_same_cycle();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule